// File: doc/BRIEF.md
# Floppy Interface Port Decoder and Control Latch

This block sits between an 8-bit processor I/O bus and a floppy disk controller core. It turns the I/O port address into selects for the controller's four registers. It also decodes a combined wait/drive-select port, a read-back port for the control latch, and a fixed extended-address port. The port group starts at one of two base addresses, and a strap input chooses which one.

A control latch holds the drive number, the density choice and the head side. From the latch the block drives an active-low density line and a master-clock select. The extended-address port holds the upper eight address bits used by DMA transfers. A read of the wait port holds the bus through a ready output until the controller raises a data request or an interrupt. The byte returned then shows, in bit 7, which of the two ended the wait.

Top module: `disk_port_decode`

## Requirements
- R1: The port group starts at F8h when `base_alt` is 0 and at 78h when `base_alt` is 1. An address outside the selected group, other than the extended port, selects nothing.
- R2: Offsets 0 to 3 from the base go to the controller. `fdc_sel` is high during the access, `fdc_idx` is the offset (0 = command/status, 1 = track, 2 = sector, 3 = data), `fdc_rd`/`fdc_wr` follow the bus strobes, and a read returns `fdc_rdata`.
- R3: A write to base+4 loads the control latch from the data byte: bits 1:0 are the drive, bit 3 = 1 selects double density, bit 6 is the side. A read at base+6 returns the latch in the same bit positions, with all other bits zero.
- R4: Reset sets drive 0, single density, side 0 and an extended address of 00h.
- R5: `dens_n` is low exactly when double density is latched. `clk16_sel` is 1 (16 MHz) in double density and 0 (8 MHz) in single density.
- R6: A write to FDh, for either base, loads `ext_addr`. A read of FDh returns it.
- R7: While the wait port (base+4) is read and neither `fdc_drq` nor `fdc_intrq` is high, `io_ready` is low. Otherwise `io_ready` is high.
- R8: A read of the wait port returns 00h when `fdc_intrq` is high, and 80h when only `fdc_drq` is high.
- R9: A write to any address other than base+4 or FDh leaves the control latch and `ext_addr` unchanged.
- R10: A read from an address that selects nothing returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| base_alt | input | 1 | Strap: 0 selects base F8h, 1 selects base 78h |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, held for the read |
| io_rdata | output | 8 | Read data |
| io_ready | output | 1 | Low stalls the current bus read |
| fdc_sel | output | 1 | Controller register access |
| fdc_idx | output | 2 | Controller register index |
| fdc_wr | output | 1 | Controller write strobe |
| fdc_rd | output | 1 | Controller read strobe |
| fdc_rdata | input | 8 | Controller read data |
| fdc_drq | input | 1 | Controller data request |
| fdc_intrq | input | 1 | Controller interrupt request |
| drv_sel | output | 2 | Selected drive |
| side_sel | output | 1 | Selected head side |
| dens_n | output | 1 | Density, low = double |
| clk16_sel | output | 1 | Master clock select, 1 = 16 MHz |
| ext_addr | output | 8 | Address bits 23:16 for DMA |

## Verification
The properties assume `io_wr` and `io_rd` are never high together, that `io_wr` lasts a single cycle per write, and that both strobes are low while reset is asserted. The bench meets these assumptions because it drives every access from one task. That task raises a single strobe at a falling edge and drops it at the next falling edge. The bench keeps the strobes low throughout reset.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  localparam int BYTE_W = 8;
  localparam int DRV_W  = 2;

  typedef enum logic [2:0] {
    PK_NONE,
    PK_FDC,
    PK_WAITDRV,
    PK_READBACK,
    PK_EXT
  } port_kind_e;

  typedef struct packed {
    logic             side;
    logic             dbl;
    logic [DRV_W-1:0] drive;
  } ctrl_t;

  localparam logic [BYTE_W-1:0] OFS_WAITDRV  = 8'd4;
  localparam logic [BYTE_W-1:0] OFS_READBACK = 8'd6;
  localparam int BIT_DBL  = 3;
  localparam int BIT_SIDE = 6;

  function automatic port_kind_e classify(input logic [BYTE_W-1:0] addr,
                                          input logic [BYTE_W-1:0] base,
                                          input logic [BYTE_W-1:0] ext);
    logic [BYTE_W-1:0] ofs;
    ofs = addr - base;
    if (addr == ext)              return PK_EXT;
    else if (ofs < 8'd4)          return PK_FDC;
    else if (ofs == OFS_WAITDRV)  return PK_WAITDRV;
    else if (ofs == OFS_READBACK) return PK_READBACK;
    else                          return PK_NONE;
  endfunction

  function automatic ctrl_t unpack_ctrl(input logic [BYTE_W-1:0] b);
    ctrl_t c;
    c.drive = b[DRV_W-1:0];
    c.dbl   = b[BIT_DBL];
    c.side  = b[BIT_SIDE];
    return c;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_ctrl(input ctrl_t c);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[DRV_W-1:0] = c.drive;
    b[BIT_DBL]   = c.dbl;
    b[BIT_SIDE]  = c.side;
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] wait_status(input logic intrq);
    return {~intrq, {(BYTE_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/dpd_decode.sv
module dpd_decode
  import dpd_pkg::*;
#(
  parameter logic [7:0] BASE_PRI = 8'hF8,
  parameter logic [7:0] BASE_SEC = 8'h78,
  parameter logic [7:0] EXT_PORT = 8'hFD
) (
  input  logic       base_alt,
  input  logic [7:0] addr,
  output port_kind_e kind,
  output logic [1:0] idx
);
  logic [7:0] base;
  assign base = base_alt ? BASE_SEC : BASE_PRI;
  assign kind = classify(addr, base, EXT_PORT);
  logic [7:0] ofs;
  assign ofs = addr - base;
  assign idx = ofs[1:0];
endmodule

// File: rtl/dpd_ctrl_latch.sv
module dpd_ctrl_latch
  import dpd_pkg::*;
#(
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             ext_we,
  input  logic [7:0]       wdata,
  output ctrl_t            ctrl_q,
  output logic [EXT_W-1:0] ext_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ext_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= unpack_ctrl(wdata);
      if (ext_we)  ext_q  <= wdata[EXT_W-1:0];
    end
  end
endmodule

// File: rtl/dpd_wait.sv
module dpd_wait
  import dpd_pkg::*;
(
  input  logic       wait_rd,
  input  logic       drq,
  input  logic       intrq,
  output logic       ready,
  output logic [7:0] status
);
  logic released;
  assign released = drq | intrq;
  assign ready    = ~(wait_rd & ~released);
  assign status   = wait_status(intrq);
endmodule

// File: rtl/disk_port_decode.sv
module disk_port_decode
  import dpd_pkg::*;
#(
  parameter logic [7:0] BASE_PRI = 8'hF8,
  parameter logic [7:0] BASE_SEC = 8'h78,
  parameter logic [7:0] EXT_PORT = 8'hFD,
  parameter int         EXT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_alt,
  input  logic [7:0]       io_addr,
  input  logic [7:0]       io_wdata,
  input  logic             io_wr,
  input  logic             io_rd,
  output logic [7:0]       io_rdata,
  output logic             io_ready,
  output logic             fdc_sel,
  output logic [1:0]       fdc_idx,
  output logic             fdc_wr,
  output logic             fdc_rd,
  input  logic [7:0]       fdc_rdata,
  input  logic             fdc_drq,
  input  logic             fdc_intrq,
  output logic [1:0]       drv_sel,
  output logic             side_sel,
  output logic             dens_n,
  output logic             clk16_sel,
  output logic [EXT_W-1:0] ext_addr
);
  port_kind_e kind;
  logic [1:0] idx;
  ctrl_t      ctrl_q;
  logic [7:0] wait_byte;

  // named events for the checker
  logic hit_fdc, hit_wait, hit_rb, hit_ext;
  logic drv_wr_evt, ext_wr_evt, wait_rd_evt;

  dpd_decode #(.BASE_PRI(BASE_PRI), .BASE_SEC(BASE_SEC), .EXT_PORT(EXT_PORT)) u_dec (
    .base_alt (base_alt),
    .addr     (io_addr),
    .kind     (kind),
    .idx      (idx)
  );

  assign hit_fdc     = (kind == PK_FDC);
  assign hit_wait    = (kind == PK_WAITDRV);
  assign hit_rb      = (kind == PK_READBACK);
  assign hit_ext     = (kind == PK_EXT);
  assign drv_wr_evt  = hit_wait & io_wr;
  assign ext_wr_evt  = hit_ext & io_wr;
  assign wait_rd_evt = hit_wait & io_rd;

  dpd_ctrl_latch #(.EXT_W(EXT_W)) u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_we (drv_wr_evt),
    .ext_we  (ext_wr_evt),
    .wdata   (io_wdata),
    .ctrl_q  (ctrl_q),
    .ext_q   (ext_addr)
  );

  dpd_wait u_wait (
    .wait_rd (wait_rd_evt),
    .drq     (fdc_drq),
    .intrq   (fdc_intrq),
    .ready   (io_ready),
    .status  (wait_byte)
  );

  assign fdc_sel = hit_fdc & (io_rd | io_wr);
  assign fdc_idx = idx;
  assign fdc_wr  = hit_fdc & io_wr;
  assign fdc_rd  = hit_fdc & io_rd;

  assign drv_sel   = ctrl_q.drive;
  assign side_sel  = ctrl_q.side;
  assign dens_n    = ~ctrl_q.dbl;
  assign clk16_sel = ctrl_q.dbl;

  always_comb begin
    unique case (kind)
      PK_FDC:      io_rdata = fdc_rdata;
      PK_WAITDRV:  io_rdata = wait_byte;
      PK_READBACK: io_rdata = pack_ctrl(ctrl_q);
      PK_EXT:      io_rdata = 8'(ext_addr);
      default:     io_rdata = 8'hFF;
    endcase
  end
endmodule

// File: rtl/dpd_checker.sv
module dpd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       base_alt,
  input logic [7:0] io_addr,
  input logic [7:0] io_wdata,
  input logic       io_wr,
  input logic       io_rd,
  input logic       io_ready,
  input logic       fdc_sel,
  input logic [1:0] fdc_idx,
  input logic       fdc_drq,
  input logic       fdc_intrq,
  input logic [1:0] drv_sel,
  input logic       side_sel,
  input logic       dens_n,
  input logic       clk16_sel,
  input logic [7:0] ext_addr,
  input logic       drv_wr_evt,
  input logic       ext_wr_evt,
  input logic       wait_rd_evt
);
  logic [7:0] base;
  assign base = base_alt ? 8'h78 : 8'hF8;

  assert_wait_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_rd_evt && !fdc_drq && !fdc_intrq) |-> !io_ready);

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_ready);

  assert_dens_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dens_n == !clk16_sel);

  assert_drv_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_wr_evt |=> (drv_sel == $past(io_wdata[1:0])) && (side_sel == $past(io_wdata[6]))
                   && (dens_n == !$past(io_wdata[3])));

  assert_ext_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_evt |=> ext_addr == $past(io_wdata));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_wr_evt || ext_wr_evt) |=> $stable(drv_sel) && $stable(ext_addr) && $stable(dens_n)
                                    && $stable(side_sel));

  assert_fdc_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_sel |-> fdc_idx == 2'(io_addr - base));

  assert_fdc_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_sel |-> (8'(io_addr - base) < 8'd4));
endmodule

bind disk_port_decode dpd_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .base_alt    (base_alt),
  .io_addr     (io_addr),
  .io_wdata    (io_wdata),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_ready    (io_ready),
  .fdc_sel     (fdc_sel),
  .fdc_idx     (fdc_idx),
  .fdc_drq     (fdc_drq),
  .fdc_intrq   (fdc_intrq),
  .drv_sel     (drv_sel),
  .side_sel    (side_sel),
  .dens_n      (dens_n),
  .clk16_sel   (clk16_sel),
  .ext_addr    (ext_addr),
  .drv_wr_evt  (drv_wr_evt),
  .ext_wr_evt  (ext_wr_evt),
  .wait_rd_evt (wait_rd_evt)
);

// File: tb/sim_disk_port_decode.sv
module sim_disk_port_decode;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_alt = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic [7:0] io_wdata = 8'h00;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_rdata;
  logic       io_ready;
  logic       fdc_sel, fdc_wr, fdc_rd;
  logic [1:0] fdc_idx;
  logic [7:0] fdc_rdata = 8'h5A;
  logic       fdc_drq = 1'b0;
  logic       fdc_intrq = 1'b0;
  logic [1:0] drv_sel;
  logic       side_sel, dens_n, clk16_sel;
  logic [7:0] ext_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  disk_port_decode u0 (
    .clk(clk), .rst_n(rst_n), .base_alt(base_alt), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .io_ready(io_ready), .fdc_sel(fdc_sel), .fdc_idx(fdc_idx), .fdc_wr(fdc_wr),
    .fdc_rd(fdc_rd), .fdc_rdata(fdc_rdata), .fdc_drq(fdc_drq), .fdc_intrq(fdc_intrq),
    .drv_sel(drv_sel), .side_sel(side_sel), .dens_n(dens_n), .clk16_sel(clk16_sel),
    .ext_addr(ext_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic alt, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    base_alt = alt; io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_start(input logic alt, input logic [7:0] a, input logic drq, input logic irq);
    @(negedge clk);
    base_alt = alt; io_addr = a; fdc_drq = drq; fdc_intrq = irq; io_rd = 1'b1;
    #2;
  endtask

  task automatic rd_end();
    @(negedge clk);
    io_rd = 1'b0; fdc_drq = 1'b0; fdc_intrq = 1'b0;
  endtask

  // vector: [33:30] req, [29:28] op (0 write, 1 read), [27] alt, [26:19] addr,
  //         [18:11] wdata, [10] drq, [9] intrq, [8:1] expected rdata, [0] expected ready
  localparam int NV = 19;
  localparam logic [33:0] VEC [NV] = '{
    {4'd3, 2'd0, 1'b0, 8'hFC, 8'h49, 1'b0, 1'b0, 8'h00, 1'b1}, // R3 drive1 dbl side1
    {4'd3, 2'd1, 1'b0, 8'hFE, 8'h00, 1'b0, 1'b0, 8'h49, 1'b1}, // R3 readback
    {4'd3, 2'd0, 1'b0, 8'hFC, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b1}, // R3 extra bits dropped
    {4'd3, 2'd1, 1'b0, 8'hFE, 8'h00, 1'b0, 1'b0, 8'h4B, 1'b1}, // R3
    {4'd6, 2'd0, 1'b0, 8'hFD, 8'h3C, 1'b0, 1'b0, 8'h00, 1'b1}, // R6 ext write
    {4'd6, 2'd1, 1'b0, 8'hFD, 8'h00, 1'b0, 1'b0, 8'h3C, 1'b1}, // R6 ext read
    {4'd2, 2'd1, 1'b0, 8'hF8, 8'h00, 1'b0, 1'b0, 8'h5A, 1'b1}, // R2 status passthrough
    {4'd2, 2'd1, 1'b0, 8'hFB, 8'h00, 1'b0, 1'b0, 8'h5A, 1'b1}, // R2 data passthrough
    {4'd8, 2'd1, 1'b0, 8'hFC, 8'h00, 1'b1, 1'b0, 8'h80, 1'b1}, // R8 drq only
    {4'd8, 2'd1, 1'b0, 8'hFC, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1}, // R8 intrq only
    {4'd8, 2'd1, 1'b0, 8'hFC, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1}, // R8 both
    {4'd7, 2'd1, 1'b0, 8'hFC, 8'h00, 1'b0, 1'b0, 8'h80, 1'b0}, // R7 stall
    {4'd9, 2'd0, 1'b0, 8'h10, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1}, // R9 stray write
    {4'd9, 2'd1, 1'b0, 8'hFE, 8'h00, 1'b0, 1'b0, 8'h4B, 1'b1}, // R9 latch kept
    {4'd1, 2'd0, 1'b1, 8'h7C, 8'h08, 1'b0, 1'b0, 8'h00, 1'b1}, // R1 alt base write
    {4'd1, 2'd1, 1'b1, 8'h7E, 8'h00, 1'b0, 1'b0, 8'h08, 1'b1}, // R1 alt readback
    {4'd1, 2'd1, 1'b1, 8'h78, 8'h00, 1'b0, 1'b0, 8'h5A, 1'b1}, // R1 alt controller
    {4'd10,2'd1, 1'b1, 8'hF8, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b1}, // R10 unmatched in alt
    {4'd10,2'd1, 1'b0, 8'h78, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b1}  // R10 unmatched in default
  };

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R4 reset values
    check("R4 drive", 32'(drv_sel), 0);
    check("R4 side", 32'(side_sel), 0);
    check("R4 dens_n", 32'(dens_n), 1);
    check("R4 ext", 32'(ext_addr), 0);
    rst_n = 1'b1;
    rd_start(1'b0, 8'hFE, 1'b0, 1'b0);
    check("R4 readback", 32'(io_rdata), 32'h00);
    check("R5 clk8 single", 32'(clk16_sel), 0);
    rd_end();

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[33:30], i);
      if (v[29:28] == 2'd0) begin
        wr(v[27], v[26:19], v[18:11]);
      end else begin
        rd_start(v[27], v[26:19], v[10], v[9]);
        check(tag, 32'(io_rdata), 32'(v[8:1]));
        check(tag, 32'(io_ready), 32'(v[0]));
        rd_end();
      end
    end

    // R5 double density now latched (vec 14 wrote 08h)
    check("R5 dens_n dbl", 32'(dens_n), 0);
    check("R5 clk16 dbl", 32'(clk16_sel), 1);
    check("R3 drive0", 32'(drv_sel), 0);

    // R6 ext port independent of base
    wr(1'b1, 8'hFD, 8'h12);
    check("R6 ext alt", 32'(ext_addr), 32'h12);

    // R2 track index and strobes
    rd_start(1'b0, 8'hF9, 1'b0, 1'b0);
    check("R2 sel", 32'(fdc_sel), 1);
    check("R2 idx", 32'(fdc_idx), 1);
    check("R2 rd", 32'(fdc_rd), 1);
    check("R2 wr", 32'(fdc_wr), 0);
    rd_end();
    @(negedge clk); base_alt = 1'b0; io_addr = 8'hFA; io_wdata = 8'h01; io_wr = 1'b1;
    #2;
    check("R2 wr strobe", 32'(fdc_wr), 1);
    check("R2 idx sector", 32'(fdc_idx), 2);
    @(negedge clk); io_wr = 1'b0;
    check("R9 fdc write keeps latch", 32'(drv_sel), 0);

    // R7 stall then release by drq
    rd_start(1'b0, 8'hFC, 1'b0, 1'b0);
    check("R7 stalled", 32'(io_ready), 0);
    @(negedge clk);
    check("R7 still stalled", 32'(io_ready), 0);
    fdc_drq = 1'b1; #2;
    check("R7 released", 32'(io_ready), 1);
    check("R8 drq end", 32'(io_rdata), 32'h80);
    rd_end();

    // R5 back to single density
    wr(1'b0, 8'hFC, 8'h02);
    check("R5 single again", 32'(dens_n), 1);
    check("R3 drive2", 32'(drv_sel), 2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule